// File: doc/BRIEF.md
# External/Status Interrupt Source Gate

This block watches six external and status conditions of one serial channel and turns qualified changes into a pending interrupt. Five of the conditions are levels: break/abort, transmit underrun/end of message, CTS, sync/hunt and DCD. The sixth is a zero-count pulse from the baud-rate generator. Each level source is compared with a registered copy of itself, so a rise or a fall counts as an event. The zero-count pulse counts as an event on its rising edge.

An 8-bit enable register, written through a simple write strobe, gates each source on its own. A group enable input gates all of them together. An event raises the interrupt only if the source's enable bit already held 1 before the cycle in which the change occurs. A condition that is already active when its bit is set therefore never interrupts by itself. Once an interrupt is pending, the block freezes a snapshot of all six levels and holds it until software issues a clear command. A channel reset discards the pending causes and the snapshot, and it keeps the enable register.

Top module: `xs_event_gate`

## Requirements
- R1: After the asynchronous reset `rst_n` is released, `irq_pend`, `src_flags` and `stat_lat` are all zero.
- R2: Enable register bit positions: bit 7 enables break/abort, bit 6 transmit underrun, bit 5 CTS, bit 4 sync/hunt, bit 3 DCD, bit 1 zero count. In `src_flags` and `stat_lat`, bit 5 is break, 4 underrun, 3 CTS, 2 sync, 1 DCD, 0 zero count. A qualified event sets only its own flag.
- R3: Register bits 2 and 0 are reserved. Writing them enables no source.
- R4: A rise or a fall of an enabled level source sets its flag and `irq_pend` at the clock edge after the change is presented.
- R5: The zero-count flag is set by a rising edge of `zc_pulse`. Holding the pulse high produces no further event.
- R6: While `grp_en` is 0, no event sets a flag. Raising `grp_en` later does not recover events that were missed.
- R7: A change counts only when the source's enable bit was already set in an earlier cycle. A change in the same cycle as the write that enables the source is ignored, and so is a level that was already active when the source was enabled.
- R8: While nothing is pending, `stat_lat` follows the input levels one cycle late. From the edge that sets the first flag, `stat_lat` holds the levels of the event cycle until a clear or channel reset.
- R9: `clr_cmd` clears all flags and `irq_pend` at the next edge, unless a qualified event occurs in that same cycle: that event's flag is then set and `stat_lat` takes the current levels.
- R10: `chan_rst` clears the flags and `stat_lat` at the next edge and keeps the enable register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| chan_rst | input | 1 | Synchronous channel reset |
| mask_we | input | 1 | Write strobe for the enable register |
| mask_wdata | input | 8 | Enable register write data |
| grp_en | input | 1 | Group enable for all sources |
| brk_in | input | 1 | Break/abort level |
| txu_in | input | 1 | Transmit underrun/end-of-message level |
| cts_in | input | 1 | CTS level |
| sync_in | input | 1 | Sync/hunt level |
| dcd_in | input | 1 | DCD level |
| zc_pulse | input | 1 | Baud generator zero-count pulse |
| clr_cmd | input | 1 | Clear pending causes and release the status snapshot |
| irq_pend | output | 1 | Interrupt pending |
| src_flags | output | 6 | Sticky per-source cause flags |
| stat_lat | output | 6 | Status snapshot, frozen while pending |

## Verification
The hardest case to reach is an event that lands in exactly the cycle in which its enable bit is written. Another is a clear command that coincides with a fresh qualified event. Random stimulus seldom lines these up, so directed steps drive the register write and the input toggle on the same falling edge, and the clear together with a toggle. Random cycles with low toggle rates, occasional writes, group gating and channel resets then run against a bench model that reproduces the pre-enable rule in its own terms.

// File: rtl/xs_pkg.sv
package xs_pkg;
  localparam int NSRC   = 6;
  localparam int NLVL   = 5;
  localparam int REG_W  = 8;
  localparam int IDX_ZC   = 0;
  localparam int IDX_DCD  = 1;
  localparam int IDX_SYNC = 2;
  localparam int IDX_CTS  = 3;
  localparam int IDX_TXU  = 4;
  localparam int IDX_BRK  = 5;
  localparam logic [REG_W-1:0] RSVD_MASK = 8'h05;

  // register bit that enables a given source index
  function automatic int src_bit(input int idx);
    case (idx)
      IDX_BRK:  return 7;
      IDX_TXU:  return 6;
      IDX_CTS:  return 5;
      IDX_SYNC: return 4;
      IDX_DCD:  return 3;
      default:  return 1;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] clean_mask(input logic [REG_W-1:0] m);
    return m & ~RSVD_MASK;
  endfunction

  function automatic logic [NSRC-1:0] mask_to_en(input logic [REG_W-1:0] m);
    logic [NSRC-1:0] e;
    for (int i = 0; i < NSRC; i++) e[i] = m[src_bit(i)];
    return e;
  endfunction
endpackage

// File: rtl/xs_cfg_reg.sv
module xs_cfg_reg
  import xs_pkg::*;
#(
  parameter int W = REG_W,
  parameter int N = NSRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [N-1:0] en_vec
);
  logic [W-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  mask_q <= '0;
    else if (we) mask_q <= clean_mask(wdata);
  end

  assign en_vec = mask_to_en(mask_q);

  AST_EN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(en_vec)); // R7
endmodule

// File: rtl/xs_change_det.sv
module xs_change_det
  import xs_pkg::*;
#(
  parameter int NL = NLVL
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [NL-1:0] lvl_in,
  input  logic        pulse_in,
  output logic [NL:0] evt,
  output logic [NL:0] cur
);
  logic [NL:0] prev_q;

  assign cur = {lvl_in, pulse_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cur;
  end

  // bit 0 is the pulse source: rising edge only
  assign evt[0] = pulse_in & ~prev_q[0];

  for (genvar g = 1; g <= NL; g++) begin : g_lvl
    assign evt[g] = cur[g] ^ prev_q[g];
  end

  AST_PULSE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    evt[0] |=> !evt[0]); // R5
endmodule

// File: rtl/xs_cause_latch.sv
module xs_cause_latch
  import xs_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         chan_rst,
  input  logic         clr,
  input  logic [N-1:0] qual,
  input  logic [N-1:0] cur,
  output logic [N-1:0] cause_q,
  output logic [N-1:0] stat_q,
  output logic         pend
);
  logic [N-1:0] cause_d;
  logic         snap_en;

  assign pend    = |cause_q;
  assign cause_d = (clr ? '0 : cause_q) | qual;
  assign snap_en = !pend || clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      stat_q  <= '0;
    end else if (chan_rst) begin
      cause_q <= '0;
      stat_q  <= '0;
    end else begin
      cause_q <= cause_d;
      if (snap_en) stat_q <= cur;
    end
  end

  AST_STAT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !clr && !chan_rst) |=> $stable(stat_q)); // R8
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !chan_rst && qual == '0) |=> (cause_q == '0)); // R9
  AST_CHAN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    chan_rst |=> (cause_q == '0 && stat_q == '0)); // R10
endmodule

// File: rtl/xs_event_gate.sv
module xs_event_gate
  import xs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chan_rst,
  input  logic       mask_we,
  input  logic [7:0] mask_wdata,
  input  logic       grp_en,
  input  logic       brk_in,
  input  logic       txu_in,
  input  logic       cts_in,
  input  logic       sync_in,
  input  logic       dcd_in,
  input  logic       zc_pulse,
  input  logic       clr_cmd,
  output logic       irq_pend,
  output logic [5:0] src_flags,
  output logic [5:0] stat_lat
);
  logic [NSRC-1:0] en_vec;
  logic [NSRC-1:0] evt_raw;
  logic [NSRC-1:0] lvl_cur;
  logic [NSRC-1:0] evt_qual;

  xs_cfg_reg #(.W(REG_W), .N(NSRC)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(mask_we), .wdata(mask_wdata), .en_vec(en_vec)
  );

  xs_change_det #(.NL(NLVL)) u_det (
    .clk(clk), .rst_n(rst_n),
    .lvl_in({brk_in, txu_in, cts_in, sync_in, dcd_in}),
    .pulse_in(zc_pulse), .evt(evt_raw), .cur(lvl_cur)
  );

  assign evt_qual = evt_raw & en_vec & {NSRC{grp_en}};

  xs_cause_latch #(.N(NSRC)) u_lat (
    .clk(clk), .rst_n(rst_n), .chan_rst(chan_rst), .clr(clr_cmd),
    .qual(evt_qual), .cur(lvl_cur),
    .cause_q(src_flags), .stat_q(stat_lat), .pend(irq_pend)
  );

  AST_GRP_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    (!grp_en && !clr_cmd && !chan_rst) |=> (src_flags == $past(src_flags))); // R6
  AST_PRE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((src_flags & ~$past(src_flags) & ~$past(en_vec)) == '0)); // R7
  AST_EDGE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_qual && !chan_rst) |=> irq_pend); // R4
endmodule

// File: tb/xs_event_gate_test.sv
`timescale 1ns/1ps
module xs_event_gate_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chan_rst = 1'b0, mask_we = 1'b0, grp_en = 1'b1, clr_cmd = 1'b0;
  logic [7:0] mask_wdata = 8'h00;
  logic brk_in = 0, txu_in = 0, cts_in = 0, sync_in = 0, dcd_in = 0, zc_pulse = 0;
  logic irq_pend;
  logic [5:0] src_flags, stat_lat;

  int checks = 0, failures = 0;
  bit done = 0;

  // bench model state
  logic [7:0] m_mask = 8'h00;
  logic [5:0] m_prev = 6'h00, m_cause = 6'h00, m_stat = 6'h00;

  always #2.5 clk = ~clk;

  xs_event_gate uut (
    .clk(clk), .rst_n(rst_n), .chan_rst(chan_rst), .mask_we(mask_we),
    .mask_wdata(mask_wdata), .grp_en(grp_en), .brk_in(brk_in), .txu_in(txu_in),
    .cts_in(cts_in), .sync_in(sync_in), .dcd_in(dcd_in), .zc_pulse(zc_pulse),
    .clr_cmd(clr_cmd), .irq_pend(irq_pend), .src_flags(src_flags), .stat_lat(stat_lat)
  );

  function automatic int en_pos(input int s);
    int t [6] = '{1, 3, 4, 5, 6, 7};
    return t[s];
  endfunction

  function automatic logic [5:0] levels();
    return {brk_in, txu_in, cts_in, sync_in, dcd_in, zc_pulse};
  endfunction

  task automatic chk(input string tag, input logic [12:0] act, input logic [12:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag);
    logic [5:0] c, ev, q, nc, ns;
    c = levels();
    for (int s = 0; s < 6; s++) begin
      ev[s] = (s == 0) ? (c[0] && !m_prev[0]) : (c[s] != m_prev[s]);
      q[s]  = ev[s] && m_mask[en_pos(s)] && grp_en;
    end
    if (chan_rst) begin
      nc = '0; ns = '0;
    end else begin
      nc = (clr_cmd ? 6'h00 : m_cause) | q;
      ns = (m_cause == 0 || clr_cmd) ? c : m_stat;
    end
    @(posedge clk);
    #0.5;
    m_prev = c; m_cause = nc; m_stat = ns;
    if (mask_we) m_mask = mask_wdata & 8'b1111_1010;
    @(negedge clk);
    chk(tag, {irq_pend, src_flags, stat_lat}, {|m_cause, m_cause, m_stat});
    mask_we = 0; clr_cmd = 0; chan_rst = 0;
  endtask

  task automatic wr(input logic [7:0] d);
    mask_we = 1; mask_wdata = d;
  endtask

  task automatic flip(input int s);
    case (s)
      0: zc_pulse = ~zc_pulse;
      1: dcd_in = ~dcd_in;
      2: sync_in = ~sync_in;
      3: cts_in = ~cts_in;
      4: txu_in = ~txu_in;
      default: brk_in = ~brk_in;
    endcase
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset", {irq_pend, src_flags, stat_lat}, 13'h0);

    // R2 / R4: walk each source alone
    for (int s = 0; s < 6; s++) begin
      wr(8'h1 << en_pos(s)); step("R2 write");
      for (int o = 1; o < 6; o++) if (o != s) flip(o);
      step("R2 others");
      chk("R2 others quiet", {7'h0, src_flags}, 13'h0);
      flip(s); step("R4 own edge");
      chk("R2 one-hot", {7'h0, src_flags}, {7'h0, 6'h1 << s});
      if (s != 0) begin
        clr_cmd = 1; step("R9 clear");
        flip(s); step("R4 falling edge");
        chk("R4 fall", {7'h0, src_flags}, {7'h0, 6'h1 << s});
      end else zc_pulse = 0;
      clr_cmd = 1; step("R9 clear");
    end

    // R3 reserved bits
    wr(8'h05); step("R3 write");
    for (int o = 1; o < 6; o++) flip(o);
    zc_pulse = 1; step("R3 toggle");
    chk("R3 no irq", {12'h0, irq_pend}, 13'h0);
    zc_pulse = 0; step("R3 idle");

    // R5 held zero count
    wr(8'h02); step("R5 write");
    zc_pulse = 1; step("R5 rise");
    chk("R5 flag", {7'h0, src_flags}, 13'h1);
    clr_cmd = 1; step("R5 clear while high");
    step("R5 held");
    chk("R5 held no event", {12'h0, irq_pend}, 13'h0);
    zc_pulse = 0; step("R5 low");

    // R6 group gate
    wr(8'hFA); grp_en = 0; step("R6 write");
    flip(3); flip(1); step("R6 gated");
    chk("R6 gated", {12'h0, irq_pend}, 13'h0);
    grp_en = 1; step("R6 reopen");
    chk("R6 no recovery", {12'h0, irq_pend}, 13'h0);

    // R7 pre-existing level and same-cycle enable
    wr(8'h00); step("R7 mask off");
    dcd_in = ~dcd_in; step("R7 change unmasked");
    wr(8'h08); step("R7 enable dcd");
    step("R7 idle");
    chk("R7 old level", {12'h0, irq_pend}, 13'h0);
    wr(8'h28); flip(3); step("R7 same cycle");
    chk("R7 same cycle", {12'h0, irq_pend}, 13'h0);
    flip(3); step("R7 later edge");
    chk("R7 later edge", {7'h0, src_flags}, 13'h08);

    // R8 frozen status, R9 clear colliding with event
    flip(4); flip(5); step("R8 frozen");
    flip(1); clr_cmd = 1; step("R9 collide");
    chk("R9 collide kept", {7'h0, src_flags}, 13'h02);
    clr_cmd = 1; step("R9 clear");

    // R10 channel reset keeps mask
    flip(1); chan_rst = 1; step("R10 chan reset");
    chk("R10 cleared", {irq_pend, src_flags, stat_lat}, 13'h0);
    flip(3); step("R10 mask kept");
    chk("R10 mask kept", {7'h0, src_flags}, 13'h08);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      for (int o = 1; o < 6; o++) if ($urandom_range(3) == 0) flip(o);
      zc_pulse = ($urandom_range(5) == 0);
      if ($urandom_range(19) == 0) wr(8'($urandom));
      grp_en = ($urandom_range(9) != 0);
      clr_cmd = ($urandom_range(11) == 0);
      chan_rst = ($urandom_range(99) == 0);
      step("R4/R8 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule